// File: doc/BRIEF.md
# Pipelined Synchronous Word Memory with Lane Writes

This block is a single-port synchronous memory. Each word is 36 bits wide and is split into four 9-bit lanes. Every lane holds 8 data bits and 1 parity bit. The block captures all of its inputs on the rising clock edge. A selected cycle is either a write or a read. A write stores the whole word or any set of lanes. A read returns the addressed word one clock later, from an output register.

Three chip enables of mixed polarity decide whether a cycle is selected. A global write strobe writes every lane, and it takes priority over the lane-write path. The lane-write path needs its own enable plus one active-low select per lane. An active-low output enable decides, without a clock, whether read data is driven. The block does not drive the first read that follows a deselected cycle. A high sleep input freezes all activity and keeps the stored contents.

Burst addressing is done upstream. Pads and power behaviour are not modelled here.

Top module: `sram_pipe`

## Requirements
- R1: A cycle is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0 at the rising edge. An unselected cycle neither writes nor starts a read.
- R2: In a selected cycle with `gwN`=0, all four lanes are written from `wData`, whatever the values of `bweN` and `bwN`.
- R3: In a selected cycle with `gwN`=1 and `bweN`=0, lane i is written when `bwN[i]`=0. Lane i is bits [9i+8:9i]. Lanes whose select is high keep their value.
- R4: A selected cycle with no active write is a read. The word at the address captured at that edge is presented in the following cycle. That word includes every write completed at an earlier edge.
- R5: `rDrive` is high only in the cycle after a read, and only while `oeN`=0. `oeN` takes effect without a clock. When `rDrive` is low, `rData` is all zeros.
- R6: A read is never driven if the cycle before it was unselected by its chip enables. Reset counts as unselected. Sleep cycles leave this history unchanged.
- R7: While `sleep`=1, no write and no read takes place, and the stored contents are kept.
- R8: After reset, `rDrive` is 0 and `rData` is zero.
- R9: When `bweN`=0 but no lane select is low, and `gwN`=1, the cycle is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| gwN | input | 1 | Global write of all lanes, active low |
| bweN | input | 1 | Lane-write enable, active low |
| bwN | input | 4 | Per-lane write selects, active low |
| oeN | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high |
| wData | input | 36 | Write data |
| rData | output | 36 | Read data, zero when not driven |
| rDrive | output | 1 | Read data is being driven |

## Verification
A write takes effect at the edge that captures it, so a read of the same address at the next edge must return the new word. Read data appears one edge after its read is captured. `rDrive` also follows `oeN` in that same cycle, without waiting for an edge. For these reasons the bench applies all stimulus just after a falling edge. It compares the outputs of the previous read at the next falling edge, before it changes `oeN`. The bench model tracks the previous-selection history and the sleep freeze cycle by cycle. This lets it predict the masked first read exactly.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic [LANES-1:0] wrLane;
    logic             rdEn;
    logic             maskFirst;
  } ctrl_strb_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             sleep,
  output ctrl_strb_t       strb
);
  logic chipSel;
  logic active;
  logic prevSelQ;
  logic [LANES-1:0] laneSel;

  assign chipSel = ~ce1N & ce2 & ~ce3N;
  assign active  = chipSel & ~sleep;

  always_comb begin
    laneSel = '0;
    if (active) begin
      if (!gwN)       laneSel = '1;
      else if (!bweN) laneSel = ~bwN;
    end
  end

  assign strb.wrLane    = laneSel;
  assign strb.rdEn      = active & (laneSel == '0);
  assign strb.maskFirst = active & (laneSel == '0) & ~prevSelQ;

  // selection history; frozen while asleep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevSelQ <= 1'b0;
    else if (!sleep) prevSelQ <= chipSel;
  end

  // R1: no activity without full chip-enable decode
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N || !ce2 || ce3N) |-> (strb.wrLane == '0 && !strb.rdEn));
  // R2: global write covers every lane
  a_r2_global_all: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && ce2 && !ce3N && !sleep && !gwN) |-> (&strb.wrLane));
  // R7: sleep blocks all strobes
  a_r7_sleep_idle: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (strb.wrLane == '0 && !strb.rdEn));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wData,
  input  logic              oeN,
  input  ctrl_strb_t        strb,
  output logic [WORD_W-1:0] rData,
  output logic              rDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] oldWord;
  logic [WORD_W-1:0] newWord;
  logic [WORD_W-1:0] rdReg;
  logic              rdValidQ;
  logic              maskQ;

  assign oldWord = mem[addr];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign newWord[i*LANE_W +: LANE_W] = strb.wrLane[i] ? wData[i*LANE_W +: LANE_W]
                                                         : oldWord[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (|strb.wrLane) mem[addr] <= newWord;
    if (strb.rdEn)    rdReg <= oldWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      maskQ    <= 1'b0;
    end else begin
      rdValidQ <= strb.rdEn;
      maskQ    <= strb.maskFirst;
    end
  end

  assign rDrive = rdValidQ & ~maskQ & ~oeN;
  assign rData  = rDrive ? rdReg : '0;

  // R5: drive only with output enable, only after a read
  a_r5_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    rDrive |-> !oeN);
  a_r5_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rDrive |-> $past(strb.rdEn));
  a_r5_quiet_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rDrive |-> (rData == '0));
  // R6: first read after deselect never driven
  a_r6_first_masked: assert property (@(posedge clk) disable iff (!rstN)
    rDrive |-> !$past(strb.maskFirst));
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
  import sram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              sleep,
  input  logic [WORD_W-1:0] wData,
  output logic [WORD_W-1:0] rData,
  output logic              rDrive
);
  ctrl_strb_t strb;

  sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .sleep(sleep), .strb(strb)
  );

  sram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wData(wData), .oeN(oeN),
    .strb(strb), .rData(rData), .rDrive(rDrive)
  );
endmodule

// File: tb/sram_pipe_bench.sv
module sram_pipe_bench;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1, oeN = 1'b1, sleep = 1'b0;
  logic [3:0] bwN = 4'hF;
  logic [35:0] wData = '0;
  logic [35:0] rData;
  logic rDrive;

  sram_pipe #(.ADDR_W(AW)) u_sram_pipe (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN), .sleep(sleep),
    .wData(wData), .rData(rData), .rDrive(rDrive)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [35:0] model [DEPTH];
  logic prevSel = 1'b0;
  logic pendRead = 1'b0, pendMask = 1'b0, pendOe = 1'b1;
  logic [35:0] pendData = '0;
  bit done = 0;

  function automatic logic [35:0] mergeLanes(logic [35:0] oldW, logic [35:0] newW, logic [3:0] en);
    logic [35:0] r = oldW;
    for (int i = 0; i < 4; i++) if (en[i]) r[i*9 +: 9] = newW[i*9 +: 9];
    return r;
  endfunction

  task automatic check(string tag);
    logic expDrive = pendRead & ~pendOe & ~pendMask;
    logic [35:0] expData = expDrive ? pendData : '0;
    checks++;
    if (rDrive !== expDrive || rData !== expData) begin
      fails++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, rDrive, rData, expDrive, expData);
    end
  endtask

  // check previous result, apply new stimulus, advance one clock
  task automatic step(string tag, logic c1, logic c2, logic c3, logic g, logic be,
                      logic [3:0] bw, logic oe, logic slp, logic [AW-1:0] a, logic [35:0] d);
    logic sel, act;
    logic [3:0] lanes;
    check(tag);
    ce1N = c1; ce2 = c2; ce3N = c3; gwN = g; bweN = be; bwN = bw;
    oeN = oe; sleep = slp; addr = a; wData = d;
    sel = ~c1 & c2 & ~c3;
    act = sel & ~slp;
    lanes = !act ? 4'h0 : (!g ? 4'hF : (!be ? ~bw : 4'h0));
    pendRead = act & (lanes == 4'h0);
    pendMask = pendRead & ~prevSel;
    pendOe   = oe;
    if (pendRead) pendData = model[a];
    if (lanes != 0) model[a] = mergeLanes(model[a], d, lanes);
    if (!slp) prevSel = sel;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [AW-1:0] a, logic [35:0] d);
    step(tag, 0, 1, 0, 0, 1, 4'hF, 0, 0, a, d);
  endtask
  task automatic rd(string tag, logic [AW-1:0] a);
    step(tag, 0, 1, 0, 1, 1, 4'hF, 0, 0, a, '0);
  endtask
  task automatic idle(string tag);
    step(tag, 1, 0, 1, 1, 1, 4'hF, 0, 0, '0, '0);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog: actual=timeout expected=finish");
    fails++; checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8");
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++) wr("R2", AW'(i), {$urandom, $urandom} & 36'hF_FFFF_FFFF);
    // R6: first read after deselect masked, next one driven
    idle("R8");
    rd("R6", 7'd5);
    rd("R6", 7'd6);
    rd("R4", 7'd7);
    // R2: global write overrides lane selects and bweN
    step("R4", 0, 1, 0, 0, 0, 4'hA, 0, 0, 7'd9, 36'h1_2345_6789);
    rd("R2", 7'd9);
    // R3: lane writes lanes 0 and 2
    step("R2", 0, 1, 0, 1, 0, 4'b1010, 0, 0, 7'd9, 36'hF_FFFF_FFFF);
    rd("R3", 7'd9);
    // R9: bweN low with no lane select is a read
    step("R3", 0, 1, 0, 1, 0, 4'hF, 0, 0, 7'd9, 36'h0);
    rd("R9", 7'd10);
    // R1: each single bad enable blocks write
    step("R9", 1, 1, 0, 0, 1, 4'hF, 0, 0, 7'd11, 36'h0);
    step("R1", 0, 0, 0, 0, 1, 4'hF, 0, 0, 7'd11, 36'h0);
    step("R1", 0, 1, 1, 0, 1, 4'hF, 0, 0, 7'd11, 36'h0);
    rd("R1", 7'd11);
    rd("R6", 7'd11);
    // R7: sleep blocks write, history kept
    step("R1", 0, 1, 0, 0, 1, 4'hF, 0, 1, 7'd12, 36'h0);
    rd("R7", 7'd12);
    rd("R7", 7'd12);
    // R5: oe high suppresses drive
    step("R7", 0, 1, 0, 1, 1, 4'hF, 1, 0, 7'd13, 36'h0);
    rd("R5", 7'd13);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned r = $urandom % 16;
      logic c1 = (r == 0), c2 = (r != 1), c3 = (r == 2);
      step("R4", c1, c2, c3, ($urandom % 4) != 0, $urandom % 2, 4'($urandom),
           ($urandom % 6) == 0, ($urandom % 12) == 0, AW'($urandom % 16),
           {$urandom, $urandom} & 36'hF_FFFF_FFFF);
    end
    idle("R4");
    idle("R5");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule